// File: doc/BRIEF.md
# NAND Controller Register Front End

This block is the register interface a host processor uses to drive a NAND flash controller. It holds a control word and a sticky 12-bit event status word, and it drives one interrupt line. It also gathers a three-word command descriptor and passes it to a downstream sequencer through a valid/ready handshake.

The host sets the run bit, which raises the command-request event. The host then writes three command words in turn to a single command offset. Once the third word is in, the descriptor goes out. The sequencer and the data path report progress as one-cycle event pulses. Each pulse sets a status bit, and the bit stays set until the host writes a one to it. Any set status bit whose mask bit is clear raises the interrupt. After the command completes, the host clears the run bit, and this also empties any partly filled descriptor.

Top module: `nand_host_regs`

## Requirements
- R1: After reset the control word reads 0x00000FFF, which masks all 12 events. Status reads 0, `irq` is low and `desc_valid` is low.
- R2: A pulse on `evt_pulse[k]` sets status bit k, and the bit stays set. The status bits, from 11 down to 0, are: ready, page done (select 0), page done (select 1), command done (select 0), command done (select 1), bad block (select 0), bad block (select 1), double-bit error, single-bit error, write-data request, read-data request, command request.
- R3: Writing the status offset with bit k = 1 clears status bit k, and a 0 leaves the bit unchanged. When an event pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: Control bit 28 is the run bit. A control write that takes it from 0 to 1 sets status bit 0. A control write while run is already 1 does not set it.
- R5: Command-offset writes made while the run bit is 0 are ignored.
- R6: Three accepted command writes fill slots 0, 1 and 2 in order. Slot k sits at bits [32k+31:32k] of `desc_words`. `desc_valid` rises after the third write and not before.
- R7: While `desc_valid` is high and `desc_ready` is low, `desc_valid` and `desc_words` hold, and command writes are ignored. One cycle with `desc_ready` high retires the descriptor.
- R8: Clearing the run bit sends the slot pointer back to slot 0, so a partly written descriptor is discarded.
- R9: `irq` is the OR of the status bits whose mask bit (control bits 11..0, 1 = blocked) is 0. `irq` follows a mask or status change in the cycle after the write.
- R10: The offsets are 0x0 for control, 0x4 for status and 0x8 for command. A read of 0x8 returns 0, and a read of control returns the last word written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_pulse | input | 12 | One-cycle event pulses from sequencer and data path |
| desc_valid | output | 1 | Descriptor available |
| desc_ready | input | 1 | Sequencer takes the descriptor |
| desc_words | output | 96 | Three descriptor words, slot 0 in the low bits |
| irq | output | 1 | Interrupt request |

## Verification
A slot pointer that does not return to 0 shows up on the next complete descriptor: its words appear rotated in `desc_words`, or `desc_valid` rises one write early. Either symptom is visible as soon as that descriptor issues. A wrong set/clear merge in the status word shows in the status read and on `irq` one cycle after the offending write or pulse. A missed run-rise detection leaves status bit 0 clear in the status read that follows the control write.

// File: rtl/nand_host_regs.sv
module nand_host_regs #(
  parameter int ADDR_W  = 4,
  parameter int WORD_W  = 32,
  parameter int EVT_W   = 12,
  parameter int RUN_BIT = 28,
  parameter int SLOTS   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [WORD_W-1:0]         bus_wdata,
  output logic [WORD_W-1:0]         bus_rdata,
  input  logic [EVT_W-1:0]          evt_pulse,
  output logic                      desc_valid,
  input  logic                      desc_ready,
  output logic [SLOTS*WORD_W-1:0]   desc_words,
  output logic                      irq
);
  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_CMD  = ADDR_W'(8);
  localparam logic [WORD_W-1:0] CTRL_RST = WORD_W'({EVT_W{1'b1}});
  localparam logic [PTR_W-1:0]  LAST_SLOT = PTR_W'(SLOTS - 1);

  logic [WORD_W-1:0] ctrl_q;
  logic [EVT_W-1:0]  stat_q;
  logic [PTR_W-1:0]  slot_q;
  logic              valid_q;

  wire wr_ctrl  = bus_wr && (bus_addr == OFF_CTRL);
  wire wr_stat  = bus_wr && (bus_addr == OFF_STAT);
  wire wr_cmd   = bus_wr && (bus_addr == OFF_CMD);
  wire run      = ctrl_q[RUN_BIT];
  wire run_rise = wr_ctrl && bus_wdata[RUN_BIT] && !run;
  wire take     = wr_cmd && run && !valid_q;
  wire last     = take && (slot_q == LAST_SLOT);

  wire [EVT_W-1:0] stat_clr = wr_stat ? bus_wdata[EVT_W-1:0] : '0;
  wire [EVT_W-1:0] stat_set = evt_pulse | EVT_W'(run_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      stat_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      stat_q <= (stat_q & ~stat_clr) | stat_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (!run)      slot_q <= '0;
      else if (take) slot_q <= last ? '0 : slot_q + PTR_W'(1);
      if (last)            valid_q <= 1'b1;
      else if (desc_ready) valid_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        desc_words[g*WORD_W +: WORD_W] <= '0;
      else if (take && slot_q == PTR_W'(g))
        desc_words[g*WORD_W +: WORD_W] <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_CTRL: bus_rdata = ctrl_q;
      OFF_STAT: bus_rdata = WORD_W'(stat_q);
      default:  bus_rdata = '0;
    endcase
  end

  assign desc_valid = valid_q;
  assign irq        = |(stat_q & ~ctrl_q[EVT_W-1:0]);
endmodule

// File: rtl/nand_host_regs_chk.sv
module nand_host_regs_chk #(
  parameter int ADDR_W  = 4,
  parameter int WORD_W  = 32,
  parameter int EVT_W   = 12,
  parameter int RUN_BIT = 28,
  parameter int SLOTS   = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_wr,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [WORD_W-1:0]       bus_wdata,
  input logic [EVT_W-1:0]        evt_pulse,
  input logic                    desc_valid,
  input logic                    desc_ready,
  input logic [SLOTS*WORD_W-1:0] desc_words,
  input logic [WORD_W-1:0]       ctrl_q,
  input logic [EVT_W-1:0]        stat_q
);
  localparam logic [EVT_W-1:0] NOT_REQ = ~EVT_W'(1);

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse)));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(4)) |=>
      ((stat_q & $past(bus_wdata[EVT_W-1:0]) & ~$past(evt_pulse) & NOT_REQ) == '0));

  assert_req_on_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[RUN_BIT] && !ctrl_q[RUN_BIT]) |=> stat_q[0]);

  assert_issue_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(desc_valid) |-> $past(ctrl_q[RUN_BIT]));

  assert_issue_on_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(desc_valid) |-> $past(bus_wr && bus_addr == ADDR_W'(8)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_words)));
endmodule

bind nand_host_regs nand_host_regs_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .EVT_W(EVT_W), .RUN_BIT(RUN_BIT), .SLOTS(SLOTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .evt_pulse(evt_pulse), .desc_valid(desc_valid),
  .desc_ready(desc_ready), .desc_words(desc_words), .ctrl_q(ctrl_q), .stat_q(stat_q)
);

// File: tb/sim_nand_host_regs.sv
module sim_nand_host_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] evt_pulse = '0;
  logic        desc_valid;
  logic        desc_ready = 1'b0;
  logic [95:0] desc_words;
  logic        irq;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_host_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_words(desc_words),
    .irq(irq)
  );

  // {wr, addr, wdata, evt, expected status, expected irq}
  localparam logic [61:0] VEC [NVEC] = '{
    {1'b0, 4'h0, 32'h0000_0000, 12'h100, 12'h100, 1'b0},
    {1'b1, 4'h0, 32'h0000_0EFF, 12'h000, 12'h100, 1'b1},
    {1'b1, 4'h4, 32'h0000_0100, 12'h000, 12'h000, 1'b0},
    {1'b1, 4'h4, 32'h0000_0000, 12'h010, 12'h010, 1'b0},
    {1'b1, 4'h4, 32'h0000_0010, 12'h010, 12'h010, 1'b0},
    {1'b1, 4'h4, 32'h0000_0FFF, 12'h000, 12'h000, 1'b0},
    {1'b1, 4'h0, 32'h1000_0EFF, 12'h000, 12'h001, 1'b0},
    {1'b1, 4'h0, 32'h1000_0EFE, 12'h000, 12'h001, 1'b1},
    {1'b1, 4'h4, 32'h0000_0001, 12'h000, 12'h000, 1'b0},
    {1'b0, 4'h0, 32'h0000_0000, 12'h800, 12'h800, 1'b0},
    {1'b1, 4'h0, 32'h0000_0000, 12'h000, 12'h800, 1'b1},
    {1'b1, 4'h4, 32'h0000_0800, 12'h000, 12'h000, 1'b0}
  };

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, r); check("R1 ctrl", 96'(r), 96'h0000_0FFF);
    rd(4'h4, r); check("R1 status", 96'(r), 96'h0);
    check("R1 irq", 96'(irq), 96'h0);
    check("R1 valid", 96'(desc_valid), 96'h0);

    // R2 R3 R4 R9 table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      bus_wr = VEC[i][61]; bus_addr = VEC[i][60:57];
      bus_wdata = VEC[i][56:25]; evt_pulse = VEC[i][24:13];
      @(negedge clk);
      bus_wr = 1'b0; evt_pulse = '0;
      rd(4'h4, r);
      check($sformatf("R2 R3 R4 status vec%0d", i), 96'(r[11:0]), 96'(VEC[i][12:1]));
      check($sformatf("R9 irq vec%0d", i), 96'(irq), 96'(VEC[i][0]));
    end

    // R10 read map
    rd(4'h0, r); check("R10 ctrl readback", 96'(r), 96'h0);
    rd(4'h8, r); check("R10 cmd reads zero", 96'(r), 96'h0);

    // R5 writes while idle are dropped
    wr(4'h8, 32'hAAAA_0001); wr(4'h8, 32'hAAAA_0002); wr(4'h8, 32'hAAAA_0003);
    check("R5 no issue while idle", 96'(desc_valid), 96'h0);

    // R8 partial descriptor dropped on run clear
    wr(4'h0, 32'h1000_0FFF);
    wr(4'h8, 32'h11); wr(4'h8, 32'h22);
    wr(4'h0, 32'h0000_0FFF);
    wr(4'h0, 32'h1000_0FFF);
    wr(4'h8, 32'h33); wr(4'h8, 32'h44);
    check("R6 not valid after two words", 96'(desc_valid), 96'h0);
    wr(4'h8, 32'h55);
    check("R6 valid after third word", 96'(desc_valid), 96'h1);
    check("R8 R6 slot order", desc_words, {32'h55, 32'h44, 32'h33});

    // R7 hold and ignore while pending
    wr(4'h8, 32'h99);
    @(negedge clk);
    check("R7 valid held", 96'(desc_valid), 96'h1);
    check("R7 words held", desc_words, {32'h55, 32'h44, 32'h33});
    desc_ready = 1'b1;
    @(negedge clk);
    desc_ready = 1'b0;
    check("R7 retired by ready", 96'(desc_valid), 96'h0);
    wr(4'h8, 32'h1); wr(4'h8, 32'h2); wr(4'h8, 32'h3);
    check("R7 next descriptor", desc_words, {32'h3, 32'h2, 32'h1});
    check("R7 next valid", 96'(desc_valid), 96'h1);

    finish_run();
  end
endmodule